// File: doc/BRIEF.md
# DRAM Bandwidth Utilization Tracker

This block sits next to a memory controller and estimates how heavily the DRAM data bus is used. The controller pulses a one-bit strobe in every clock cycle in which it issues a column access command. The tracker adds these pulses into an activity counter over a fixed measurement window. The window lasts four row-cycle times, and the row-cycle time is supplied as a static configuration value.

At each window boundary the counter is not cleared. It is halved, so recent history carries into the next window and the estimate moves with some hysteresis. The count at the close of each window is compared against quarter, half and three-quarter fractions of a configured peak count. The peak count is derived from the channel count and the channel width. The comparison produces a two-bit quartile level and a high-usage flag. A prefetch controller uses these two outputs to shape its reward values.

Top module: `bw_tracker`

## Requirements
- R1: Each clock cycle with `cas_strobe` high adds one to the activity counter. A cycle with the strobe low leaves the counter unchanged, except at a window boundary.
- R2: A window lasts exactly 4×`cfg_trc` clock cycles, counted from reset release. The outputs take their new value at the clock edge that ends the last cycle of the window. `cfg_trc` must be nonzero.
- R3: At a window boundary the counter becomes half (right shift by one) of its value including any strobe in that last cycle. It is not cleared.
- R4: The thresholds are computed with shifts and an add, with no divider: low = `cfg_peak`>>2, mid = `cfg_peak`>>1, top = (`cfg_peak`>>1)+(`cfg_peak`>>2).
- R5: `level_o` is encoded as follows, using the window-end count with strictly-greater comparisons: 3 when the count is above top, 2 when above mid, 1 when above low, and 0 otherwise.
- R6: `high_o` is 1 exactly when the window-end count is above the top threshold. Otherwise it is 0.
- R7: The counter saturates at 2^CNT_W−1 and never wraps around.
- R8: `level_o` and `high_o` change only at a window boundary or on reset. They hold their value during every other cycle.
- R9: A synchronous active-low reset clears the counter, the window timer, `level_o` and `high_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cas_strobe | input | 1 | One column access command issued this cycle |
| cfg_trc | input | TRC_W | Row-cycle time in clocks; the window is four times this value |
| cfg_peak | input | CNT_W | Peak command count per window |
| level_o | output | 2 | Quartile level of the last window |
| high_o | output | 1 | High bandwidth usage flag |

## Verification
The bound checker watches four things on every cycle. It checks that the counter holds when there is no strobe and no boundary. It checks that the counter sticks at its maximum under further strobes. It checks that a boundary at least halves the count. It checks that the outputs stay unchanged away from boundaries and that the high flag only appears with level 3.

Other behaviour can only be shown by the directed scenarios. These cover the exact placement of the boundary for a given `cfg_trc` and the strict threshold edges, including a peak that is not a multiple of four. They also cover the carried-over half count that lowers the level over successive idle windows, and the saturation that keeps a very busy window from reading as idle.

// File: rtl/bw_pkg.sv
package bw_pkg;
    typedef enum logic [1:0] {
        LVL_Q0 = 2'd0,
        LVL_Q1 = 2'd1,
        LVL_Q2 = 2'd2,
        LVL_Q3 = 2'd3
    } lvl_e;
endpackage

// File: rtl/bw_win_timer.sv
module bw_win_timer #(
    parameter int TRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRC_W-1:0] cfg_trc,
    output logic             win_end
);
    localparam int TW = TRC_W + 2;
    localparam logic [TW-1:0] ONE = 1;

    typedef struct packed {
        logic [TW-1:0] tick;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [TW-1:0] win_len;

    always_comb begin
        win_len = {cfg_trc, 2'b00};
        win_end = (tmr_q.tick == win_len - ONE);
        tmr_d   = tmr_q;
        if (win_end) tmr_d.tick = '0;
        else         tmr_d.tick = tmr_q.tick + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/bw_thresh.sv
module bw_thresh #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] th_lo,
    output logic [CNT_W-1:0] th_mid,
    output logic [CNT_W-1:0] th_top
);
    always_comb begin
        th_lo  = peak >> 2;
        th_mid = peak >> 1;
        th_top = th_mid + th_lo;
    end
endmodule

// File: rtl/bw_classify.sv
module bw_classify #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] val,
    input  logic [CNT_W-1:0] th_lo,
    input  logic [CNT_W-1:0] th_mid,
    input  logic [CNT_W-1:0] th_top,
    output bw_pkg::lvl_e     level,
    output logic             high
);
    always_comb begin
        high = (val > th_top);
        if (high)              level = bw_pkg::LVL_Q3;
        else if (val > th_mid) level = bw_pkg::LVL_Q2;
        else if (val > th_lo)  level = bw_pkg::LVL_Q1;
        else                   level = bw_pkg::LVL_Q0;
    end
endmodule

// File: rtl/bw_tracker.sv
module bw_tracker #(
    parameter int CNT_W = 12,
    parameter int TRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cas_strobe,
    input  logic [TRC_W-1:0] cfg_trc,
    input  logic [CNT_W-1:0] cfg_peak,
    output logic [1:0]       level_o,
    output logic             high_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        bw_pkg::lvl_e     level;
        logic             high;
    } trk_t;

    trk_t state_d, state_q;

    logic             win_end;
    logic [CNT_W-1:0] th_lo, th_mid, th_top;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] act_cnt;
    bw_pkg::lvl_e     cls_level;
    logic             cls_high;

    bw_win_timer #(.TRC_W(TRC_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_trc (cfg_trc),
        .win_end (win_end)
    );

    bw_thresh #(.CNT_W(CNT_W)) u_thresh (
        .peak   (cfg_peak),
        .th_lo  (th_lo),
        .th_mid (th_mid),
        .th_top (th_top)
    );

    bw_classify #(.CNT_W(CNT_W)) u_cls (
        .val    (cnt_inc),
        .th_lo  (th_lo),
        .th_mid (th_mid),
        .th_top (th_top),
        .level  (cls_level),
        .high   (cls_high)
    );

    always_comb begin
        state_d = state_q;
        if (cas_strobe && (state_q.cnt != CNT_MAX)) cnt_inc = state_q.cnt + ONE;
        else                                       cnt_inc = state_q.cnt;
        if (win_end) begin
            state_d.cnt   = cnt_inc >> 1;
            state_d.level = cls_level;
            state_d.high  = cls_high;
        end else begin
            state_d.cnt   = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cnt   <= '0;
            state_q.level <= bw_pkg::LVL_Q0;
            state_q.high  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_cnt = state_q.cnt;
    assign level_o = state_q.level;
    assign high_o  = state_q.high;
endmodule

// File: rtl/bw_tracker_chk.sv
module bw_tracker_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cas_strobe,
    input logic             win_end,
    input logic [CNT_W-1:0] act_cnt,
    input logic [1:0]       level_o,
    input logic             high_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = 1;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_strobe && !win_end) |=> $stable(act_cnt)); // R1

    AST_HALVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (act_cnt <= ($past(act_cnt) >> 1) + ONE)); // R3

    AST_HIGH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        high_o |-> (level_o == 2'd3)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cnt == CNT_MAX && cas_strobe && !win_end) |=> (act_cnt == CNT_MAX)); // R7

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(level_o) && $stable(high_o))); // R8
endmodule

bind bw_tracker bw_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cas_strobe (cas_strobe),
    .win_end    (win_end),
    .act_cnt    (act_cnt),
    .level_o    (level_o),
    .high_o     (high_o)
);

// File: tb/bw_tracker_tb.sv
module bw_tracker_tb;
    localparam int CNT_W = 6;
    localparam int TRC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cas_strobe = 1'b0;
    logic [TRC_W-1:0] cfg_trc = 8'd4;
    logic [CNT_W-1:0] cfg_peak = 6'd16;
    logic [1:0]       level_o;
    logic             high_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    bw_tracker #(.CNT_W(CNT_W), .TRC_W(TRC_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cas_strobe (cas_strobe),
        .cfg_trc    (cfg_trc),
        .cfg_peak   (cfg_peak),
        .level_o    (level_o),
        .high_o     (high_o)
    );

    task automatic check(input string req, input logic [1:0] exp_lvl, input logic exp_hi);
        n_tests++;
        if (level_o !== exp_lvl || high_o !== exp_hi) begin
            n_fail++;
            $display("FAIL %s: level=%0d high=%0d expected level=%0d high=%0d",
                     req, level_o, high_o, exp_lvl, exp_hi);
        end
    endtask

    task automatic do_reset(input logic [TRC_W-1:0] trc, input logic [CNT_W-1:0] peak);
        @(negedge clk);
        rst_n = 1'b0;
        cas_strobe = 1'b0;
        cfg_trc = trc;
        cfg_peak = peak;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives strobes in the first n_on of n_tot cycles; ends at a negedge.
    task automatic run(input int n_on, input int n_tot);
        for (int i = 0; i < n_tot; i++) begin
            cas_strobe = (i < n_on);
            @(posedge clk);
            @(negedge clk);
        end
        cas_strobe = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(8'd4, 6'd16);
        check("R9 reset state", 2'd0, 1'b0);
    endtask

    task automatic t_quartiles();
        do_reset(8'd4, 6'd16); run(4, 16);  check("R5 n=4 at low edge", 2'd0, 1'b0);
        do_reset(8'd4, 6'd16); run(5, 16);  check("R5 n=5 above low", 2'd1, 1'b0);
        do_reset(8'd4, 6'd16); run(9, 16);  check("R5 n=9 above mid", 2'd2, 1'b0);
        do_reset(8'd4, 6'd16); run(12, 16); check("R6 n=12 at top edge", 2'd2, 1'b0);
        do_reset(8'd4, 6'd16); run(13, 16); check("R6 n=13 above top", 2'd3, 1'b1);
    endtask

    task automatic t_odd_peak();
        // peak 10: low 2, mid 5, top 7
        do_reset(8'd4, 6'd10); run(7, 16); check("R4 peak10 n=7", 2'd2, 1'b0);
        do_reset(8'd4, 6'd10); run(8, 16); check("R4 peak10 n=8", 2'd3, 1'b1);
        do_reset(8'd4, 6'd10); run(3, 16); check("R4 peak10 n=3", 2'd1, 1'b0);
    endtask

    task automatic t_window_len();
        do_reset(8'd2, 6'd16);
        run(7, 7);
        check("R2 before boundary", 2'd0, 1'b0);
        run(1, 1);
        check("R2 at 8-cycle boundary", 2'd1, 1'b0);
    endtask

    task automatic t_decay();
        do_reset(8'd4, 6'd16);
        run(16, 16); check("R3 full window", 2'd3, 1'b1);
        run(0, 16);  check("R3 carry 8", 2'd1, 1'b0);
        run(0, 16);  check("R3 carry 4", 2'd0, 1'b0);
    endtask

    task automatic t_stable();
        do_reset(8'd4, 6'd16);
        run(13, 16); check("R8 setup", 2'd3, 1'b1);
        run(2, 10);  check("R8 mid window hold", 2'd3, 1'b1);
        run(0, 6);   check("R1 6+2=8", 2'd1, 1'b0);
    endtask

    task automatic t_saturate();
        // peak 40: low 10, mid 20, top 30; window 128 cycles
        do_reset(8'd32, 6'd40);
        run(128, 128); check("R7 saturated window", 2'd3, 1'b1);
        run(0, 128);   check("R7 carry 31", 2'd3, 1'b1);
        run(0, 128);   check("R7 carry 15", 2'd1, 1'b0);
    endtask

    task automatic t_reset_mid();
        do_reset(8'd4, 6'd16);
        run(16, 16);
        run(5, 5);
        do_reset(8'd4, 6'd16);
        check("R9 reset clears outputs", 2'd0, 1'b0);
        run(0, 16);
        check("R9 counter cleared", 2'd0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_quartiles();
        t_odd_peak();
        t_window_len();
        t_decay();
        t_stable();
        t_saturate();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule